// File: doc/BRIEF.md
# Wavefront Atomic Add Coalescer

This block takes one atomic add or subtract from a group of 64 parallel lanes that all target the same memory word. It folds them into a single memory operation. The lane group arrives as one request carrying an active mask, an optional helper mask, and either one shared value or one value per lane. The block forms an effective mask from the two masks and gives each lane a rank. A lane's rank is the number of effective lanes below it. The block elects the lowest effective lane as leader, computes the aggregate operand, and issues exactly one request on the memory side.

When the memory returns the old value of the word, the block rebuilds the result each lane would have seen from its own atomic. It takes the old value and applies the lane's offset with the same operation. The offset is the sum of the contributions of all effective lanes ranked below that lane. All results are delivered together in a single result pulse.

Two request modes exist. In shared-value mode, the operand is the value times the effective lane count, and a lane's offset is the value times its rank. In per-lane mode, the operand is the total of the effective lanes' values, and the offsets come from an exclusive prefix sum. Per-lane mode is built only when `DATA_W` is 32. At other widths (for example 64), every request is handled in shared-value mode.

The request port follows valid/ready. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The memory request is held, unchanged, until `mem_req_ready` is seen high. The response side has no back-pressure: `mem_rsp_valid` is a one-cycle strobe and is taken only while a response is awaited.

Top module: `wave_atomic_merge`

## Requirements
- R1: `req_ready` is high exactly when `busy` is low. Once a request with a non-empty effective mask is taken, `busy` stays high and no further request is taken until the cycle after the result pulse.
- R2: The effective mask is `req_active & ~req_helper`. Helper lanes add nothing to the operand, take no rank, and receive no result.
- R3: Each request with a non-empty effective mask produces exactly one memory request. `mem_req_lane` carries the index of the lowest effective lane.
- R4: In shared-value mode (`req_uniform`=1), `mem_req_operand` equals `req_scalar` times the number of effective lanes.
- R5: In per-lane mode (`req_uniform`=0), `mem_req_operand` equals the sum of the values of the effective lanes, where lane i's value is `req_vals[i*DATA_W +: DATA_W]`.
- R6: `mem_req_sub` equals the request's `req_sub`, where 1 means subtract. Lane i's result is the returned old value plus its offset for add, or minus its offset for subtract. The offset is the sum of the contributions of the effective lanes below lane i.
- R7: `res_valid` is high for exactly one cycle, in the cycle after the response is taken. `res_mask` equals the effective mask, and the result slots of non-effective lanes read zero.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_valid`, `mem_req_operand`, `mem_req_sub` and `mem_req_lane` hold their values.
- R9: A request whose effective mask is all zero issues no memory request, produces no result pulse, and leaves `req_ready` high in the next cycle.
- R10: All sums, products and results wrap modulo 2^`DATA_W`.
- R11: A lane in the upper half (bits 63..32) of the mask counts the effective lanes of the lower half in its rank.
- R12: After reset, `req_ready` is high, and `busy`, `mem_req_valid` and `res_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lane-group request valid |
| req_ready | output | 1 | Block can take a request |
| req_sub | input | 1 | 1 = subtract, 0 = add |
| req_uniform | input | 1 | 1 = shared value in `req_scalar`, 0 = per-lane values |
| req_scalar | input | DATA_W | Value shared by all lanes |
| req_active | input | LANES | Lanes taking part |
| req_helper | input | LANES | Lanes to exclude |
| req_vals | input | LANES*DATA_W | Per-lane values, lane i at bits i*DATA_W |
| busy | output | 1 | A lane group is in flight |
| mem_req_valid | output | 1 | Merged memory request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_sub | output | 1 | Operation of the merged request |
| mem_req_lane | output | $clog2(LANES) | Leader lane index |
| mem_req_operand | output | DATA_W | Aggregate operand |
| mem_rsp_valid | input | 1 | Old-value response strobe |
| mem_rsp_old | input | DATA_W | Old memory value |
| res_valid | output | 1 | Result pulse |
| res_mask | output | LANES | Lanes receiving a result |
| res_vals | output | LANES*DATA_W | Per-lane results, lane i at bits i*DATA_W |

## Verification
The tests cover both request modes and both operations. Shared-value mode is tried with alternating lanes and with the full mask. This separates a multiply by count from a multiply by rank. Per-lane mode is tried with lane values that are all distinct, using an irregular mask and a mask set only in the upper half. This exposes prefix, leader and half-crossing errors. Further tests cover a helper mask that removes the lower lanes, a mask that cancels to zero, wrap-around operands, and delayed memory acceptance. These tell masking, the empty case, modular arithmetic and request holding apart from the basic sum.

// File: rtl/wam_pkg.sv
package wam_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } wam_state_e;
endpackage

// File: rtl/wam_ballot.sv
module wam_ballot #(
  parameter int LANES = 64,
  parameter int CNT_W = $clog2(LANES + 1),
  parameter int IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0]       mask,
  output logic [LANES*CNT_W-1:0] rank,
  output logic [CNT_W-1:0]       count,
  output logic [IDX_W-1:0]       leader
);
  localparam int HALF = LANES / 2;

  logic [CNT_W-1:0] rank_a [LANES];
  logic [CNT_W-1:0] lo_tot;
  logic [CNT_W-1:0] hi_run;

  // lower half ranks, then upper half based on lower-half population
  always_comb begin
    lo_tot = '0;
    for (int i = 0; i < HALF; i++) begin
      rank_a[i] = lo_tot;
      lo_tot = lo_tot + CNT_W'(mask[i]);
    end
    hi_run = lo_tot;
    for (int i = HALF; i < LANES; i++) begin
      rank_a[i] = hi_run;
      hi_run = hi_run + CNT_W'(mask[i]);
    end
    count = hi_run;
  end

  always_comb begin
    leader = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (mask[i]) leader = IDX_W'(i);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rank
    assign rank[g*CNT_W +: CNT_W] = rank_a[g];
  end
endmodule

// File: rtl/wam_scan.sv
module wam_scan #(
  parameter int LANES = 64,
  parameter int W     = 32,
  parameter int CNT_W = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]       mask,
  input  logic                   uniform,
  input  logic [W-1:0]           scalar,
  input  logic [LANES*W-1:0]     vals,
  input  logic [LANES*CNT_W-1:0] rank,
  input  logic [CNT_W-1:0]       count,
  output logic [LANES*W-1:0]     offs,
  output logic [W-1:0]           total
);
  if (W == 32) begin : g_perlane
    logic [W-1:0] run;
    always_comb begin
      run = '0;
      for (int i = 0; i < LANES; i++) begin
        if (uniform)
          offs[i*W +: W] = W'(scalar * W'(rank[i*CNT_W +: CNT_W]));
        else
          offs[i*W +: W] = run;
        if (mask[i]) run = run + vals[i*W +: W];
      end
      total = uniform ? W'(scalar * W'(count)) : run;
    end
  end else begin : g_uniform
    logic unused_ok;
    assign unused_ok = &{1'b0, uniform, vals, mask};
    always_comb begin
      for (int i = 0; i < LANES; i++)
        offs[i*W +: W] = W'(scalar * W'(rank[i*CNT_W +: CNT_W]));
      total = W'(scalar * W'(count));
    end
  end
endmodule

// File: rtl/wam_fanout.sv
module wam_fanout #(
  parameter int LANES = 64,
  parameter int W     = 32
) (
  input  logic [W-1:0]       old_val,
  input  logic               sub,
  input  logic [LANES-1:0]   mask,
  input  logic [LANES*W-1:0] offs,
  output logic [LANES*W-1:0] vals
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign vals[g*W +: W] = !mask[g] ? '0 :
                            sub ? old_val - offs[g*W +: W]
                                : old_val + offs[g*W +: W];
  end
endmodule

// File: rtl/wave_atomic_merge.sv
module wave_atomic_merge #(
  parameter int LANES  = 64,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LANES),
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_sub,
  input  logic                    req_uniform,
  input  logic [DATA_W-1:0]       req_scalar,
  input  logic [LANES-1:0]        req_active,
  input  logic [LANES-1:0]        req_helper,
  input  logic [LANES*DATA_W-1:0] req_vals,
  output logic                    busy,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic                    mem_req_sub,
  output logic [IDX_W-1:0]        mem_req_lane,
  output logic [DATA_W-1:0]       mem_req_operand,
  input  logic                    mem_rsp_valid,
  input  logic [DATA_W-1:0]       mem_rsp_old,
  output logic                    res_valid,
  output logic [LANES-1:0]        res_mask,
  output logic [LANES*DATA_W-1:0] res_vals
);
  import wam_pkg::*;

  wam_state_e              state_q;
  logic [LANES-1:0]        mask_q;
  logic                    sub_q;
  logic                    uni_q;
  logic [DATA_W-1:0]       scalar_q;
  logic [LANES*DATA_W-1:0] vals_q;
  logic [DATA_W-1:0]       old_q;

  logic [LANES-1:0]        eff_mask;
  logic                    take;
  logic [LANES*CNT_W-1:0]  rank;
  logic [CNT_W-1:0]        count;
  logic [LANES*DATA_W-1:0] offs;
  logic [DATA_W-1:0]       total;

  assign eff_mask = req_active & ~req_helper;
  assign req_ready = (state_q == ST_IDLE);
  assign take = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mask_q   <= '0;
      sub_q    <= 1'b0;
      uni_q    <= 1'b0;
      scalar_q <= '0;
      vals_q   <= '0;
      old_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (take && eff_mask != '0) begin
          mask_q   <= eff_mask;
          sub_q    <= req_sub;
          uni_q    <= req_uniform;
          scalar_q <= req_scalar;
          vals_q   <= req_vals;
          state_q  <= ST_ISSUE;
        end
        ST_ISSUE: if (mem_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          old_q   <= mem_rsp_old;
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  wam_ballot #(.LANES(LANES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ballot (
    .mask   (mask_q),
    .rank   (rank),
    .count  (count),
    .leader (mem_req_lane)
  );

  wam_scan #(.LANES(LANES), .W(DATA_W), .CNT_W(CNT_W)) u_scan (
    .mask    (mask_q),
    .uniform (uni_q),
    .scalar  (scalar_q),
    .vals    (vals_q),
    .rank    (rank),
    .count   (count),
    .offs    (offs),
    .total   (total)
  );

  wam_fanout #(.LANES(LANES), .W(DATA_W)) u_fanout (
    .old_val (old_q),
    .sub     (sub_q),
    .mask    (mask_q),
    .offs    (offs),
    .vals    (res_vals)
  );

  assign busy            = (state_q != ST_IDLE);
  assign mem_req_valid   = (state_q == ST_ISSUE);
  assign mem_req_sub     = sub_q;
  assign mem_req_operand = total;
  assign res_valid       = (state_q == ST_DONE);
  assign res_mask        = res_valid ? mask_q : '0;
endmodule

// File: rtl/wam_checker.sv
module wam_checker #(
  parameter int LANES  = 64,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LANES-1:0]  req_active,
  input logic [LANES-1:0]  req_helper,
  input logic              busy,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_sub,
  input logic [DATA_W-1:0] mem_req_operand,
  input logic              res_valid,
  input logic [LANES-1:0]  res_mask
);
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R1
  AST_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_active & ~req_helper) != '0) |=> busy); // R1
  AST_REQ_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_operand) && $stable(mem_req_sub))); // R8
  AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R7
  AST_RES_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_mask != '0)); // R9
  AST_RES_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !mem_req_valid); // R3
endmodule

bind wave_atomic_merge wam_checker #(.LANES(LANES), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/wave_atomic_merge_test.sv
module wave_atomic_merge_test;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 64;
  localparam int W = 32;
  localparam int IDX_W = $clog2(LANES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_sub = 1'b0, req_uniform = 1'b0;
  logic [W-1:0] req_scalar = '0;
  logic [LANES-1:0] req_active = '0, req_helper = '0;
  logic [LANES*W-1:0] req_vals = '0;
  logic req_ready, busy, mem_req_valid, mem_req_sub, res_valid;
  logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [W-1:0] mem_rsp_old = '0;
  logic [IDX_W-1:0] mem_req_lane;
  logic [W-1:0] mem_req_operand;
  logic [LANES-1:0] res_mask;
  logic [LANES*W-1:0] res_vals;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_atomic_merge #(.LANES(LANES), .DATA_W(W)) uut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_vals(input int kind);
    for (int i = 0; i < LANES; i++)
      case (kind)
        0: req_vals[i*W +: W] = W'(i * 7 + 1);
        1: req_vals[i*W +: W] = 32'hF000_0000;
        default: req_vals[i*W +: W] = W'(1000 + i * i);
      endcase
  endtask

  // one lane-group request with a memory model; delay = cycles mem_req_ready is held low
  task automatic run_wave(input string tag, input bit uni, input bit sub, input logic [W-1:0] scal,
                          input logic [LANES-1:0] act, input logic [LANES-1:0] help,
                          input logic [W-1:0] old, input int delay);
    logic [LANES-1:0] eff;
    logic [W-1:0] pre [LANES];
    logic [W-1:0] tot, v, op_seen;
    int lead, waited, bad;
    eff = act & ~help;
    tot = '0; lead = -1;
    for (int i = 0; i < LANES; i++) begin
      pre[i] = tot;
      v = uni ? scal : req_vals[i*W +: W];
      if (eff[i]) begin
        if (lead < 0) lead = i;
        tot = tot + v;
      end
    end
    @(negedge clk);
    chk(req_ready === 1'b1, {tag, " R1 ready before request"}, 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_uniform = uni; req_sub = sub; req_scalar = scal;
    req_active = act; req_helper = help;
    @(negedge clk);
    req_valid = 1'b0;
    if (eff == '0) begin
      for (int k = 0; k < 3; k++) begin
        chk(!mem_req_valid && !res_valid && req_ready, {tag, " R9 empty mask inert"},
            64'({mem_req_valid, res_valid, req_ready}), 64'b001);
        @(negedge clk);
      end
      return;
    end
    waited = 0;
    while (!mem_req_valid && waited < 10) begin
      @(negedge clk); waited++;
    end
    chk(mem_req_valid === 1'b1, {tag, " R3 memory request issued"}, 64'(mem_req_valid), 64'd1);
    chk(req_ready === 1'b0 && busy === 1'b1, {tag, " R1 blocked while busy"},
        64'({req_ready, busy}), 64'b01);
    chk(mem_req_operand === tot, {tag, uni ? " R4 R10 shared operand" : " R5 R10 per-lane operand"},
        64'(mem_req_operand), 64'(tot));
    chk(int'(mem_req_lane) == lead, {tag, " R3 R11 leader lane"}, 64'(mem_req_lane), 64'(lead));
    chk(mem_req_sub === sub, {tag, " R6 operation"}, 64'(mem_req_sub), 64'(sub));
    op_seen = mem_req_operand;
    for (int k = 0; k < delay; k++) begin
      @(negedge clk);
      chk(mem_req_valid === 1'b1 && mem_req_operand === op_seen, {tag, " R8 request held"},
          64'(mem_req_operand), 64'(op_seen));
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk(mem_req_valid === 1'b0, {tag, " R3 single request"}, 64'(mem_req_valid), 64'd0);
    mem_rsp_valid = 1'b1; mem_rsp_old = old;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk(res_valid === 1'b1, {tag, " R7 result pulse"}, 64'(res_valid), 64'd1);
    chk(res_mask === eff, {tag, " R2 R7 result mask"}, res_mask, eff);
    bad = 0;
    for (int i = 0; i < LANES; i++) begin
      v = !eff[i] ? '0 : (sub ? old - pre[i] : old + pre[i]);
      if (res_vals[i*W +: W] !== v) begin
        if (bad == 0) chk(1'b0, $sformatf("%s R6 R10 lane %0d result", tag, i), 64'(res_vals[i*W +: W]), 64'(v));
        bad++;
      end
    end
    if (bad == 0) chk(1'b1, "R6", 0, 0);
    @(negedge clk);
    chk(res_valid === 1'b0 && req_ready === 1'b1, {tag, " R7 R1 pulse ends, ready"},
        64'({res_valid, req_ready}), 64'b01);
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    set_vals(0);
    #1;
    chk(req_ready === 1'b1 && busy === 1'b0 && mem_req_valid === 1'b0 && res_valid === 1'b0,
        "R12 reset state", 64'({req_ready, busy, mem_req_valid, res_valid}), 64'b1000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk(req_ready === 1'b1 && busy === 1'b0, "R12 after reset", 64'({req_ready, busy}), 64'b10);
    run_wave("shared add alt", 1'b1, 1'b0, 32'd5, {32{2'b10}}, '0, 32'd100, 0);
    run_wave("shared sub full", 1'b1, 1'b1, 32'd3, '1, '0, 32'd1000, 0);
    run_wave("per-lane add", 1'b0, 1'b0, 32'd0, 64'h0F0F_00FF_1234_8001, '0, 32'd77, 1);
    set_vals(2);
    run_wave("per-lane sub upper", 1'b0, 1'b1, 32'd0, 64'hF0F0_0001_0000_0000, '0, 32'd5, 0);
    run_wave("R2 helper removed", 1'b0, 1'b0, 32'd0, '1, 64'h0000_FFFF_FFFF_FFFF, 32'h10, 0);
    run_wave("R9 empty", 1'b0, 1'b0, 32'd0, 64'hFF, 64'hFF, 32'd0, 0);
    set_vals(1);
    run_wave("R10 wrap per-lane", 1'b0, 1'b0, 32'd0, '1, '0, 32'hFFFF_FFF0, 0);
    run_wave("R10 wrap shared", 1'b1, 1'b1, 32'h8000_0001, 64'h8000_0000_0000_0007, '0, 32'd2, 0);
    run_wave("R8 backpressure", 1'b1, 1'b0, 32'd9, 64'h0000_0001_8000_0000, '0, 32'd4, 3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule